// File: doc/BRIEF.md
# Ramped Gain and Soft-Mute Stage

This stage multiplies a stream of signed stereo samples by an unsigned fixed-point gain. The gain code has one integer bit and seven fractional bits, so it spans zero up to just under two in steps of 1/128. Code 0x7F (1 − 1/128) is the usual working setting because it leaves a little headroom for ripple in later filters.

The applied gain never jumps. When software writes a new gain code, the gain the stage applies moves one step toward that code for each accepted input sample. Raising the mute bit makes the effective target zero, and the gain ramps down at the same rate. Dropping the mute bit ramps the gain back up to the programmed code. The stage rounds each product back to the sample width and clamps any result that falls outside full scale. A status output shows when the ramp has come to rest.

Top module: `gain_ramp_mute`

## Requirements
- R1: After reset the applied gain is 0, out_valid is low, both output samples are 0, and at_target is high while gain_code is 0 and mute is low.
- R2: For each cycle with in_valid high, out_valid is high in the next cycle and low otherwise. Each output sample equals floor((sample × g + 64) / 128), where g is the applied gain held before that sample's step: the result is rounded, with halves going toward +infinity.
- R3: A rounded result above 2^19 − 1 is output as 0x7FFFF, and one below −2^19 is output as 0x80000.
- R4: Each accepted sample moves the applied gain by exactly one code toward the effective target, and leaves it unchanged once it is equal to the target. So a change of N codes takes N samples.
- R5: The applied gain does not change in cycles where in_valid is low, whatever gain_code and mute do.
- R6: While mute is high the effective target is 0, so the gain ramps down and then stays at 0 even if gain_code changes. After mute falls, the gain ramps from its current value to gain_code.
- R7: If the target changes during a ramp, the next sample still uses the current applied gain, and the ramp turns toward the new target from that value.
- R8: at_target is high exactly when the applied gain equals the effective target (0 when muted, otherwise gain_code). It reacts to gain_code and mute in the same cycle.
- R9: The left and right channels use the same applied gain and are scaled independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| gain_code | input | 8 | Target gain, 1.7 unsigned fixed point |
| mute | input | 1 | Soft-mute request |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |
| at_target | output | 1 | Applied gain equals effective target |

## Verification
The assertions check on every cycle the following rules on the applied gain. It moves by at most one code for each accepted sample. It stays fixed when no sample arrives. It falls by one under mute until it reaches zero. It does not move once it is at rest. out_valid follows in_valid with a delay of one cycle. The bench's scenarios are needed to show the arithmetic: rounding of half values, clamping at both rails, and the exact sequence of gains seen by successive samples. They also cover the turn of a ramp when the target changes part-way, muting that holds while the code changes, and reset in the middle of operation.

// File: rtl/gr_pkg.sv
package gr_pkg;
    localparam int unsigned SAMPLE_W_DEF = 20;
    localparam int unsigned GAIN_W_DEF   = 8;
    localparam int unsigned FRAC_W_DEF   = 7;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/gr_step.sv
module gr_step
    import gr_pkg::*;
#(
    parameter int unsigned GW = GAIN_W_DEF
) (
    input  logic [GW-1:0] cur,
    input  logic [GW-1:0] tgt,
    input  logic          adv,
    output logic [GW-1:0] nxt,
    output logic          rest
);
    ramp_dir_e dir;

    always_comb begin
        if (cur < tgt) begin
            dir = RAMP_UP;
        end else if (cur > tgt) begin
            dir = RAMP_DOWN;
        end else begin
            dir = RAMP_HOLD;
        end
    end

    always_comb begin
        nxt = cur;
        if (adv) begin
            unique case (dir)
                RAMP_UP:   nxt = cur + GW'(1);
                RAMP_DOWN: nxt = cur - GW'(1);
                default:   nxt = cur;
            endcase
        end
    end

    assign rest = (dir == RAMP_HOLD);
endmodule

// File: rtl/gr_scale.sv
module gr_scale
    import gr_pkg::*;
#(
    parameter int unsigned SW = SAMPLE_W_DEF,
    parameter int unsigned GW = GAIN_W_DEF,
    parameter int unsigned FW = FRAC_W_DEF
) (
    input  logic [SW-1:0] sample,
    input  logic [GW-1:0] gain,
    output logic [SW-1:0] result
);
    localparam int unsigned PW = SW + GW + 1;
    localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (SW - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (SW - 1));
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FW - 1);

    logic signed [PW-1:0] sx;
    logic signed [PW-1:0] gx;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        sx      = $signed({{(GW + 1){sample[SW-1]}}, sample});
        gx      = $signed({{(SW + 1){1'b0}}, gain});
        prod    = sx * gx;
        shifted = (prod + HALF) >>> FW;
        if (shifted > MAXV) begin
            result = MAXV[SW-1:0];
        end else if (shifted < MINV) begin
            result = MINV[SW-1:0];
        end else begin
            result = shifted[SW-1:0];
        end
    end
endmodule

// File: rtl/gain_ramp_mute.sv
module gain_ramp_mute
    import gr_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
    parameter int unsigned GAIN_W   = GAIN_W_DEF,
    parameter int unsigned FRAC_W   = FRAC_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic [GAIN_W-1:0]   gain_code,
    input  logic                mute,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                at_target
);
    localparam int unsigned NCH = 2;

    typedef struct packed {
        logic [GAIN_W-1:0]             gain;
        logic                          vld;
        logic [NCH-1:0][SAMPLE_W-1:0]  smp;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [GAIN_W-1:0]            tgt_d;
    logic [GAIN_W-1:0]            gain_nxt_d;
    logic                         rest_d;
    logic [NCH-1:0][SAMPLE_W-1:0] smp_in_d;
    logic [NCH-1:0][SAMPLE_W-1:0] smp_sc_d;

    assign tgt_d       = mute ? '0 : gain_code;
    assign smp_in_d[0] = in_left;
    assign smp_in_d[1] = in_right;

    gr_step #(.GW(GAIN_W)) u_step (
        .cur  (st_q.gain),
        .tgt  (tgt_d),
        .adv  (in_valid),
        .nxt  (gain_nxt_d),
        .rest (rest_d)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        gr_scale #(.SW(SAMPLE_W), .GW(GAIN_W), .FW(FRAC_W)) u_scale (
            .sample (smp_in_d[ch]),
            .gain   (st_q.gain),
            .result (smp_sc_d[ch])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.gain = gain_nxt_d;
        st_d.vld  = in_valid;
        if (in_valid) begin
            st_d.smp = smp_sc_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_left  = st_q.smp[0];
    assign out_right = st_q.smp[1];
    assign at_target = rest_d;
endmodule

// File: rtl/gr_check.sv
module gr_check #(
    parameter int unsigned GW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          mute,
    input logic          out_valid,
    input logic          at_target,
    input logic [GW-1:0] gain
);
    a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (gain == $past(gain)) || (gain == $past(gain) + GW'(1))
                     || (gain == $past(gain) - GW'(1)));

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(gain));

    a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r6_mute_down: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute && gain != '0) |=> gain == $past(gain) - GW'(1));

    a_r8_rest_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && at_target) |=> gain == $past(gain));
endmodule

bind gain_ramp_mute gr_check #(.GW(GAIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mute      (mute),
    .out_valid (out_valid),
    .at_target (at_target),
    .gain      (st_q.gain)
);

// File: tb/tb_gain_ramp_mute.sv
module tb_gain_ramp_mute;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [19:0] in_left = '0;
    logic [19:0] in_right = '0;
    logic [7:0]  gain_code = '0;
    logic        mute = 1'b0;
    logic        out_valid;
    logic [19:0] out_left;
    logic [19:0] out_right;
    logic        at_target;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [19:0] got_l, got_r;
    logic got_v;

    // {gain code, input sample, expected output}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'd128, 20'd12345,  20'd12345},
        {8'd128, 20'hFFFF9,  20'hFFFF9},
        {8'd64,  20'd3,      20'd2},
        {8'd64,  20'hFFFFD,  20'hFFFFF},
        {8'd127, 20'd1000,   20'd992},
        {8'd130, 20'h7FFFF,  20'h7FFFF},
        {8'd192, 20'd100,    20'd150},
        {8'd192, 20'hFFF9C,  20'hFFF6A},
        {8'd255, 20'h7FFFF,  20'h7FFFF},
        {8'd255, 20'h80000,  20'h80000},
        {8'd0,   20'h12345,  20'd0},
        {8'd0,   20'h80000,  20'd0}
    };

    gain_ramp_mute dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .gain_code(gain_code), .mute(mute),
        .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right), .at_target(at_target)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [19:0] act, input logic [19:0] exp);
        check(req, act === exp, $signed(act), $signed(exp));
    endtask

    task automatic send(input logic [19:0] l, input logic [19:0] r);
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
        got_l = out_left;
        got_r = out_right;
        got_v = out_valid;
    endtask

    task automatic ramp_to(input logic [7:0] code);
        gain_code = code;
        #1;
        for (int i = 0; i < 300; i++) begin
            if (at_target) break;
            send(20'd0, 20'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", out_valid == 1'b0, out_valid, 0);
        chk_eq("R1 out_left", out_left, 20'd0);
        check("R1 at_target", at_target == 1'b1, at_target, 1);
        rst_n = 1'b1;
        @(negedge clk);
        send(20'd128, 20'd128);
        chk_eq("R1 gain zero after reset", got_l, 20'd0);

        // R4 ramp up by one per sample, R8 status
        gain_code = 8'd5;
        #1;
        check("R8 not at target after write", at_target == 1'b0, at_target, 0);
        for (int k = 0; k < 6; k++) begin
            send(20'd128, 20'd128);
            chk_eq("R4 ramp up output", got_l, 20'(k));
            check("R2 out_valid pulse", got_v == 1'b1, got_v, 1);
            if (k == 3) check("R8 mid ramp", at_target == 1'b0, at_target, 0);
            if (k == 4) check("R8 reached", at_target == 1'b1, at_target, 1);
        end

        // R5 idle cycles do not move gain; R2 no valid without input
        gain_code = 8'd50;
        repeat (10) @(negedge clk);
        check("R2 out_valid idle", out_valid == 1'b0, out_valid, 0);
        gain_code = 8'd5;
        send(20'd128, 20'd128);
        chk_eq("R5 gain held when idle", got_l, 20'd5);

        // R6 mute ramps down to zero
        mute = 1'b1;
        for (int k = 0; k < 7; k++) begin
            send(20'd128, 20'd128);
            chk_eq("R6 mute ramp down", got_l, (k < 5) ? 20'(5 - k) : 20'd0);
            if (k == 3) check("R8 muting not done", at_target == 1'b0, at_target, 0);
        end
        check("R8 muted at rest", at_target == 1'b1, at_target, 1);
        gain_code = 8'd9;
        #1;
        check("R8 muted code change", at_target == 1'b1, at_target, 1);
        send(20'd128, 20'd128);
        send(20'd128, 20'd128);
        chk_eq("R6 stays zero while muted", got_l, 20'd0);

        // R6 release ramps back up, R7 retarget mid ramp
        mute = 1'b0;
        for (int k = 0; k < 3; k++) begin
            send(20'd128, 20'd128);
            chk_eq("R6 unmute ramp up", got_l, 20'(k));
        end
        gain_code = 8'd1;
        send(20'd128, 20'd128);
        chk_eq("R7 no jump on retarget", got_l, 20'd3);
        send(20'd128, 20'd128);
        chk_eq("R7 turns downward", got_l, 20'd2);
        check("R8 retarget reached", at_target == 1'b1, at_target, 1);
        send(20'd128, 20'd128);
        chk_eq("R7 settles", got_l, 20'd1);

        // R9 channels independent
        ramp_to(8'd128);
        send(20'd5, 20'hFFFF7);
        chk_eq("R9 left", got_l, 20'd5);
        chk_eq("R9 right", got_r, 20'hFFFF7);

        // R2 and R3 vector table
        for (int v = 0; v < NVEC; v++) begin
            ramp_to(VEC[v][47:40]);
            send(VEC[v][39:20], VEC[v][39:20]);
            chk_eq((v == 5 || v == 8 || v == 9) ? "R3 saturation" : "R2 scale",
                   got_l, VEC[v][19:0]);
            chk_eq("R9 right matches", got_r, VEC[v][19:0]);
        end

        // R1 reset in operation
        ramp_to(8'd40);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        gain_code = 8'd128;
        #1;
        check("R1 at_target after reset", at_target == 1'b0, at_target, 0);
        send(20'd128, 20'd128);
        chk_eq("R1 gain restarts at zero", got_l, 20'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule